// File: doc/BRIEF.md
# Comparator Duty-Cycle Error Estimator

This block turns the one-bit output of an external voltage comparator into a signed digital error word. The comparator compares a scaled, rippling output voltage against a fixed reference. Near regulation its output is a square wave at twice the line frequency, and the duty cycle of that wave shows how far the average voltage sits from the set point. The block runs from a slow system clock, about 24.4 kHz, and oversamples the comparator bit. It filters out switching noise with a short agreement filter. A measurement window runs from one falling edge of the filtered bit to the next. The block counts the high cycles and the low cycles in each window and reports a scaled difference once per window.

The same strobe that closes a window also tells a downstream voltage-loop compensator when to update. If the comparator stays stuck at one level, a count limit forces the strobe, so updates never stop. When the result stays pinned at the end of its linear range for more than one window, the block widens the reported magnitude by a fixed extension. This lets the loop recover faster from large transients, and an output flag shows that the extension is active.

Top module: `cmp_duty_err`

## Requirements
- R1: The filtered bit `cmp_clean` changes to 1 only after the raw input has been sampled 1 on `DEB_LEN` (5) consecutive clock edges, and changes to 0 only after the same number of 0 samples. Otherwise it holds. A raw pulse of 4 cycles or less in either direction never reaches `cmp_clean`.
- R2: `upd_stb` is exactly one clock wide. It rises in the first cycle in which `cmp_clean` reads 0 after reading 1.
- R3: Each window counts the cycles with `cmp_clean`=1 as high time and the cycles with `cmp_clean`=0 as low time. The cycle in which the strobe fires is the first cycle counted in the next window. For a square wave of period P cycles, strobes are therefore P cycles apart.
- R4: If either count has reached 2^CNT_W-1 (255) and the current level would increment it again, a strobe is forced. With the input stuck high or low, strobes come every 255 cycles.
- R5: One cycle after each strobe, `err_vld` pulses for one cycle and `err_out` (signed 9-bit two's complement) takes floor(GAIN*(high-low)/2^CNT_W), with GAIN=16. Equal high and low counts give exactly 0. `err_out` holds between updates.
- R6: A window result is saturated when it is ≥ GAIN-1 or ≤ -(GAIN-1). The first saturated window is reported unchanged. For every later saturated window that directly follows a saturated one, EXT (10) is added to the magnitude: +25 for the top end, -26 for the bottom end. `sat_flag` is 1 while such an extended result is presented.
- R7: The first window that is not saturated clears `sat_flag` and is reported without extension.
- R8: While `rst_n` is low, and after it is released, `cmp_clean`, `upd_stb`, `err_vld` and `sat_flag` are 0 and `err_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_raw | input | 1 | Raw comparator output |
| cmp_clean | output | 1 | Filtered comparator level |
| upd_stb | output | 1 | One-cycle window-close / loop-update strobe |
| err_out | output | 9 | Signed error word |
| sat_flag | output | 1 | Range extension active |
| err_vld | output | 1 | One-cycle pulse when `err_out` updates |

## Verification
The bench sweeps the duty cycle over a 244-cycle period and a 203-cycle period and compares every settled window with the floor formula. An off-by-one in window ownership would show up as a shifted strobe spacing or as a nonzero result at half duty. Stuck-high and stuck-low inputs check the 255-cycle forced strobe. A wrapping counter would instead report a tiny error and stop the updates. The same inputs check that the extension appears only on the second saturated window, and that the first unsaturated window clears it. Bursts of 4-cycle glitches on either base level must leave `cmp_clean` untouched. A filter that is one stage short would let them through and close windows early.

// File: rtl/cde_pkg.sv
// Shared types for the comparator duty-cycle error estimator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cde_pkg;

    // Reason a measurement window was closed.
    typedef enum logic [1:0] {
        CLOSE_NONE  = 2'd0,
        CLOSE_EDGE  = 2'd1,
        CLOSE_OVFHI = 2'd2,
        CLOSE_OVFLO = 2'd3
    } close_cause_e;

endpackage

// File: rtl/cde_debounce.sv
// Agreement filter: the output follows the input only after DEPTH equal
// consecutive samples. Assumes DEPTH >= 2 and an input already in the clk domain
// or tolerant of one metastable sample (the first stage absorbs it).
module cde_debounce #(
    parameter int DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam logic [DEPTH-1:0] ALL_ONE  = {DEPTH{1'b1}};
    localparam logic [DEPTH-1:0] ALL_ZERO = '0;

    logic [DEPTH-1:0] hist;
    logic             lvl_q;

    // Shift the newest raw sample into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[DEPTH-2:0], din};
    end

    // Change level only on unanimous history, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                lvl_q <= 1'b0;
        else if (hist == ALL_ONE)  lvl_q <= 1'b1;
        else if (hist == ALL_ZERO) lvl_q <= 1'b0;
    end

    assign dout = lvl_q;

    AST_DEB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_q) |-> $past(hist) == ALL_ONE); // R1
    AST_DEB_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl_q) |-> $past(hist) == ALL_ZERO); // R1

endmodule

// File: rtl/cde_window.sv
// Window timer: closes a window on each falling edge of the filtered level,
// or when a count is about to pass its maximum, and counts high/low cycles.
// Assumes: the level input is already filtered (no single-cycle chatter).
module cde_window
    import cde_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    output logic             stb,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic         lvl_d;
    close_cause_e cause;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    // Decide whether and why the current window closes this cycle.
    always_comb begin
        if (lvl_d && !lvl)                cause = CLOSE_EDGE;
        else if (lvl && hi_cnt == CNT_MAX) cause = CLOSE_OVFHI;
        else if (!lvl && lo_cnt == CNT_MAX) cause = CLOSE_OVFLO;
        else                               cause = CLOSE_NONE;
    end

    assign stb = (cause != CLOSE_NONE);

    // Count the current cycle into the running window, or start a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else if (stb) begin
            hi_cnt <= lvl ? CNT_W'(1) : '0;
            lo_cnt <= lvl ? '0 : CNT_W'(1);
        end else if (lvl) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R2
    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (int'(hi_cnt) + int'(lo_cnt)) == 1); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && hi_cnt == CNT_MAX) |=> hi_cnt == CNT_W'(1)); // R4
    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && lo_cnt == CNT_MAX) |=> lo_cnt == CNT_W'(1)); // R4

endmodule

// File: rtl/cde_scale.sv
// Converts a closed window's high/low counts into a signed error word and
// applies the range extension after consecutive saturated windows.
// Assumes: GAIN*(2^CNT_W) and GAIN+EXT fit in a 32-bit int and in ERR_W bits.
module cde_scale #(
    parameter int CNT_W = 8,
    parameter int ERR_W = 9,
    parameter int GAIN  = 16,
    parameter int EXT   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb,
    input  logic [CNT_W-1:0]        hi_cnt,
    input  logic [CNT_W-1:0]        lo_cnt,
    output logic signed [ERR_W-1:0] err,
    output logic                    vld,
    output logic                    sat
);
    localparam int SAT_LIM = GAIN - 1;
    localparam int EXT_LIM = SAT_LIM + EXT;

    int   lin_val;
    int   out_val;
    logic sat_now;
    logic ext_now;
    logic prev_sat;

    // Linear estimate, saturation test and extension of the closing window.
    always_comb begin
        lin_val = ((int'(hi_cnt) - int'(lo_cnt)) * GAIN) >>> CNT_W;
        sat_now = (lin_val >= SAT_LIM) || (lin_val <= -SAT_LIM);
        ext_now = sat_now && prev_sat;
        if (ext_now && lin_val > 0)  out_val = lin_val + EXT;
        else if (ext_now)            out_val = lin_val - EXT;
        else                         out_val = lin_val;
    end

    // Register the result, the saturation history and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err      <= '0;
            vld      <= 1'b0;
            sat      <= 1'b0;
            prev_sat <= 1'b0;
        end else begin
            vld <= stb;
            if (stb) begin
                err      <= ERR_W'(out_val);
                sat      <= ext_now;
                prev_sat <= sat_now;
            end
        end
    end

    AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> vld); // R5
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> $stable(err)); // R5
    AST_EXT_MAG: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> (int'(err) >= EXT_LIM || int'(err) <= -EXT_LIM)); // R6
    AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat) |-> (vld && int'(err) < SAT_LIM && int'(err) > -SAT_LIM)); // R7

endmodule

// File: rtl/cmp_duty_err.sv
// Top of the comparator duty-cycle error estimator: filter, window timer and
// error scaling in series. Assumes cmp_raw is slow compared with clk
// (oversampled) and that the reset is synchronous and active low.
module cmp_duty_err #(
    parameter int DEB_LEN = 5,
    parameter int CNT_W   = 8,
    parameter int ERR_W   = 9,
    parameter int GAIN    = 16,
    parameter int EXT     = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_raw,
    output logic                    cmp_clean,
    output logic                    upd_stb,
    output logic signed [ERR_W-1:0] err_out,
    output logic                    sat_flag,
    output logic                    err_vld
);
    logic             lvl;
    logic             stb;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;

    cde_debounce #(.DEPTH(DEB_LEN)) u_deb (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_raw),
        .dout (lvl)
    );

    cde_window #(.CNT_W(CNT_W)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .stb   (stb),
        .hi_cnt(hi_cnt),
        .lo_cnt(lo_cnt)
    );

    cde_scale #(
        .CNT_W(CNT_W),
        .ERR_W(ERR_W),
        .GAIN (GAIN),
        .EXT  (EXT)
    ) u_scl (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .hi_cnt(hi_cnt),
        .lo_cnt(lo_cnt),
        .err   (err_out),
        .vld   (err_vld),
        .sat   (sat_flag)
    );

    assign cmp_clean = lvl;
    assign upd_stb   = stb;

    AST_STB_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_clean) |-> upd_stb); // R2

endmodule

// File: tb/test_cmp_duty_err.sv
// Self-checking bench for cmp_duty_err: duty sweeps at two periods, stuck
// inputs, glitch bursts and saturation extension entry/exit.
module test_cmp_duty_err;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_raw = 1'b0;
    logic              cmp_clean, upd_stb, sat_flag, err_vld;
    logic signed [8:0] err_out;

    int n_run = 0, n_fail = 0;
    int cyc = 0, last_t = 0, last_gap = 0;
    int clean_hi = 0, clean_lo = 0, stb_wide = 0, stb_miss = 0;
    logic prev_clean = 1'b0, prev_stb = 1'b0;
    int mode = 0, per = 244, hi_len = 122;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmp_duty_err i_cmp_duty_err (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cmp_clean(cmp_clean),
        .upd_stb(upd_stb), .err_out(err_out), .sat_flag(sat_flag), .err_vld(err_vld)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stimulus generator: 0 square, 1 stuck high, 2 stuck low,
    // 3 low with 4-cycle high glitches, 4 high with 4-cycle low glitches.
    initial begin
        @(posedge rst_n);
        forever begin
            if (mode == 1 || mode == 2) begin
                cmp_raw = (mode == 1);
                @(negedge clk);
            end else if (mode == 3 || mode == 4) begin
                for (int i = 0; i < 12; i++) begin
                    cmp_raw = (i < 4) ? (mode == 3) : (mode == 4);
                    @(negedge clk);
                end
            end else begin
                for (int i = 0; i < hi_len; i++) begin cmp_raw = 1'b1; @(negedge clk); end
                for (int i = hi_len; i < per; i++) begin cmp_raw = 1'b0; @(negedge clk); end
            end
        end
    end

    // Monitor: strobe spacing, strobe width, strobe on falling filtered level.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (upd_stb) begin last_gap = cyc - last_t; last_t = cyc; end
            if (upd_stb && prev_stb) stb_wide++;
            if (prev_clean && !cmp_clean && !upd_stb) stb_miss++;
            if (cmp_clean) clean_hi++; else clean_lo++;
        end
        prev_clean = cmp_clean;
        prev_stb = upd_stb;
    end

    // Watchdog.
    initial begin
        while (cyc < 150000 && !done) @(negedge clk);
        if (!done) begin
            chk(0, "watchdog", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic wait_vld(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!err_vld) @(negedge clk);
        end
    endtask

    function automatic int exp_err(input int hi, input int lo);
        return ((hi - lo) * 16) >>> 8;
    endfunction

    initial begin
        int e;
        bit seen_plain;
        repeat (4) @(negedge clk);
        chk(cmp_clean == 0 && upd_stb == 0 && err_vld == 0 && sat_flag == 0 && err_out == 0,
            "R8 outputs in reset", int'(err_out), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(cmp_clean == 0 && upd_stb == 0 && err_vld == 0 && sat_flag == 0 && err_out == 0,
            "R8 outputs after release", int'(err_out), 0);

        // R3/R5 duty sweeps at two periods.
        for (int p = 0; p < 2; p++) begin
            int pp = (p == 0) ? 244 : 203;
            int hmax = pp - 10;
            for (int h = 10; h <= hmax; h += 16) begin
                mode = 0; per = pp; hi_len = h;
                wait_vld(5);
                e = exp_err(h, pp - h);
                chk(int'(err_out) == e, $sformatf("R5 err P=%0d H=%0d", pp, h), int'(err_out), e);
                chk(sat_flag == 0, "R6 no extension in linear range", sat_flag, 0);
                chk(last_gap == pp, $sformatf("R3 strobe spacing P=%0d", pp), last_gap, pp);
            end
        end
        per = 244; hi_len = 122;
        wait_vld(5);
        chk(err_out == 0, "R5 equal high/low gives zero", int'(err_out), 0);

        // R4/R6 stuck high.
        mode = 1; seen_plain = 0;
        for (int k = 0; k < 6; k++) begin
            wait_vld(1);
            if (err_out == 15 && !sat_flag) seen_plain = 1;
        end
        chk(seen_plain, "R6 first saturated window unextended (+15)", 0, 1);
        chk(err_out == 25 && sat_flag, "R6 extended high result", int'(err_out), 25);
        chk(last_gap == 255, "R4 forced strobe stuck high", last_gap, 255);

        // R7 exit from extension.
        mode = 0; per = 244; hi_len = 122;
        for (int k = 0; k < 10; k++) begin
            wait_vld(1);
            if (err_out < 15 && err_out > -15) break;
        end
        chk(sat_flag == 0, "R7 first linear window clears flag", sat_flag, 0);
        chk(err_out < 15 && err_out > -15, "R7 unextended after exit", int'(err_out), 0);
        wait_vld(4);
        chk(err_out == 0 && !sat_flag, "R7 settled after exit", int'(err_out), 0);

        // R4/R6 stuck low.
        mode = 2; seen_plain = 0;
        for (int k = 0; k < 6; k++) begin
            wait_vld(1);
            if (err_out == -16 && !sat_flag) seen_plain = 1;
        end
        chk(seen_plain, "R6 first saturated window unextended (-16)", 0, 1);
        chk(err_out == -26 && sat_flag, "R6 extended low result", int'(err_out), -26);
        chk(last_gap == 255, "R4 forced strobe stuck low", last_gap, 255);

        // R1 glitch bursts on a low base.
        mode = 3; clean_hi = 0;
        wait_vld(3);
        chk(clean_hi == 0, "R1 high glitches filtered", clean_hi, 0);
        chk(err_out == -26 && last_gap == 255, "R1 low base still stuck", int'(err_out), -26);

        // R1 glitch bursts on a high base.
        mode = 4;
        wait_vld(2);
        clean_lo = 0;
        wait_vld(4);
        chk(clean_lo == 0, "R1 low glitches filtered", clean_lo, 0);
        chk(err_out == 25 && sat_flag, "R1 high base extended", int'(err_out), 25);

        chk(stb_wide == 0, "R2 strobe single cycle", stb_wide, 0);
        chk(stb_miss == 0, "R2 strobe on every falling level", stb_miss, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule